// File: doc/BRIEF.md
# SECDED Codec for a 64-bit Memory Word

This block protects a 64-bit memory word with an 8-bit check byte. It can correct any one flipped bit and detect any two. On the write side, a combinational encoder turns the write data into the check byte that is stored next to the word. On the read side, the word and its stored check byte arrive together with a one-cycle valid strobe. The decoder works out the check byte again, XORs it with the stored one to get an 8-bit syndrome, and sorts the result into one of four outcome states. The corrected word, the syndrome, the outcome flags and the index of the failing bit are registered one cycle after the strobe.

The parity-check matrix is fixed. Every data column has odd weight (three or five ones), and each check bit has a column with a single one. A single flip therefore gives an odd-weight syndrome that names the bit. A double flip gives a nonzero even-weight syndrome, which matches no column.

The decoder keeps one registered outcome state. It is loaded on each strobe and held between strobes:
- CLEAN: the syndrome is zero.
- FIX_DATA: the syndrome equals one data column.
- FIX_CHECK: the syndrome has a single one.
- MULTI: any other nonzero syndrome.

The only transition is a reload from the newly classified syndrome when `rd_valid` is high. Reset returns the state to CLEAN.

Top module: `secded_codec`

## Requirements
- R1: `wr_chk[j]` is the XOR of every data bit i whose matrix column has bit j set. The 64 columns are listed in the package, indexed by data bit. For example, data bit 0 alone gives 8'hF4 and data bit 63 alone gives 8'h0B.
- R2: One cycle after `rd_valid` is high, `out_valid` is high for exactly one cycle. `out_syn` then equals the check byte recomputed from `rd_data`, XORed with `rd_chk`.
- R3: A zero syndrome passes `rd_data` unchanged, with `out_ce` = 0, `out_ue` = 0 and `out_idx` = 0.
- R4: When data bit i (0..63) is flipped alone, the syndrome equals column i. The decoder restores the bit, asserts `out_ce` and reports `out_idx` = i.
- R5: When check bit j (0..7) is flipped alone, the syndrome is 1<<j. The data passes unchanged, `out_ce` is asserted and `out_idx` = 64 + j.
- R6: Any nonzero syndrome that matches no data column and has more than one bit set is uncorrectable. This covers every double flip. The decoder sets `out_ue` = 1, `out_ce` = 0 and `out_idx` = 0, and passes `rd_data` without change.
- R7: Syndrome 8'h03, from flipping check bits 0 and 1 together, reports `out_ue`.
- R8: While `rd_valid` is low, the registered outputs keep their values and `out_valid` stays low.
- R9: After reset, `out_valid`, `out_data`, `out_syn`, `out_ce`, `out_ue` and `out_idx` are all zero.
- R10: `out_ce` and `out_ue` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Data word to encode |
| wr_chk | output | 8 | Check byte for `wr_data` (combinational) |
| rd_valid | input | 1 | Read word and check byte valid |
| rd_data | input | 64 | Data word read from memory |
| rd_chk | input | 8 | Check byte read from memory |
| out_valid | output | 1 | Decoded result valid (one cycle after `rd_valid`) |
| out_data | output | 64 | Corrected data word |
| out_syn | output | 8 | Syndrome |
| out_ce | output | 1 | Single-bit error corrected |
| out_ue | output | 1 | Uncorrectable error detected |
| out_idx | output | 7 | Failing bit: 0..63 for data, 64..71 for check |

## Verification
The bench builds the codec with its default widths: 64 data bits and 8 check bits, which gives a 7-bit failing-bit index. These are the only widths the fixed column table supports. At these widths it is practical to flip every one of the 72 bit positions on its own, and to pair every data bit with a second data bit or a check bit. Together these reach every outcome state and both ends of the index range.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [1:0] {
        CLEAN     = 2'd0,
        FIX_DATA  = 2'd1,
        FIX_CHECK = 2'd2,
        MULTI     = 2'd3
    } outcome_e;

    // Parity-check column for each data bit; all have odd weight.
    function automatic logic [7:0] column_of(input int unsigned bit_no);
        logic [7:0] c;
        case (bit_no)
            0:  c = 8'hF4;  1: c = 8'hF1;  2: c = 8'hEC;  3: c = 8'hEA;
            4:  c = 8'hE9;  5: c = 8'hE6;  6: c = 8'hE5;  7: c = 8'hE3;
            8:  c = 8'hDC;  9: c = 8'hDA; 10: c = 8'hD9; 11: c = 8'hD6;
            12: c = 8'hD5; 13: c = 8'hD3; 14: c = 8'hCE; 15: c = 8'hCB;
            16: c = 8'hB5; 17: c = 8'hB0; 18: c = 8'hAD; 19: c = 8'hAB;
            20: c = 8'hA8; 21: c = 8'hA7; 22: c = 8'hA4; 23: c = 8'hA2;
            24: c = 8'h9D; 25: c = 8'h9B; 26: c = 8'h98; 27: c = 8'h97;
            28: c = 8'h94; 29: c = 8'h92; 30: c = 8'h8F; 31: c = 8'h8A;
            32: c = 8'h75; 33: c = 8'h70; 34: c = 8'h6D; 35: c = 8'h6B;
            36: c = 8'h68; 37: c = 8'h67; 38: c = 8'h64; 39: c = 8'h62;
            40: c = 8'h5E; 41: c = 8'h5B; 42: c = 8'h58; 43: c = 8'h57;
            44: c = 8'h54; 45: c = 8'h52; 46: c = 8'h4F; 47: c = 8'h4A;
            48: c = 8'h34; 49: c = 8'h31; 50: c = 8'h2C; 51: c = 8'h2A;
            52: c = 8'h29; 53: c = 8'h26; 54: c = 8'h25; 55: c = 8'h23;
            56: c = 8'h1C; 57: c = 8'h1A; 58: c = 8'h19; 59: c = 8'h16;
            60: c = 8'h15; 61: c = 8'h13; 62: c = 8'h0E; 63: c = 8'h0B;
            default: c = 8'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/secded_encode.sv
module secded_encode #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    import secded_pkg::*;

    // Each check bit folds in the data bits whose column marks it.
    always_comb begin
        chk = '0;
        for (int i = 0; i < DATA_W; i++) begin
            chk = chk ^ (column_of(i) & {CHK_W{data[i]}});
        end
    end

endmodule

// File: rtl/secded_locate.sv
module secded_locate #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int IDX_W  = 7
) (
    input  logic [CHK_W-1:0]      syn,
    output secded_pkg::outcome_e  kind,
    output logic [IDX_W-1:0]      idx,
    output logic [DATA_W-1:0]     flip
);
    import secded_pkg::*;

    logic [IDX_W-1:0] data_idx;
    logic [IDX_W-1:0] chk_idx;
    logic             chk_hit;

    always_comb begin
        flip     = '0;
        data_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (syn == column_of(i)) begin
                flip[i]  = 1'b1;
                data_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        chk_idx = '0;
        chk_hit = ($countones(syn) == 1);
        for (int j = 0; j < CHK_W; j++) begin
            if (syn[j]) chk_idx = IDX_W'(DATA_W + j);
        end
    end

    always_comb begin
        if (syn == '0) begin
            kind = CLEAN;
            idx  = '0;
        end else if (|flip) begin
            kind = FIX_DATA;
            idx  = data_idx;
        end else if (chk_hit) begin
            kind = FIX_CHECK;
            idx  = chk_idx;
        end else begin
            kind = MULTI;
            idx  = '0;
        end
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    localparam int IDX_W = $clog2(DATA_W + CHK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_chk,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CHK_W-1:0]  out_syn,
    output logic              out_ce,
    output logic              out_ue,
    output logic [IDX_W-1:0]  out_idx
);
    import secded_pkg::*;

    logic [CHK_W-1:0]  recomputed;
    logic [CHK_W-1:0]  syn_d;
    outcome_e          kind_d;
    outcome_e          kind_q;
    logic [IDX_W-1:0]  idx_d;
    logic [DATA_W-1:0] flip_d;

    secded_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_wr (
        .data (wr_data),
        .chk  (wr_chk)
    );

    secded_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_rd (
        .data (rd_data),
        .chk  (recomputed)
    );

    assign syn_d = recomputed ^ rd_chk;

    secded_locate #(.DATA_W(DATA_W), .CHK_W(CHK_W), .IDX_W(IDX_W)) u_locate (
        .syn  (syn_d),
        .kind (kind_d),
        .idx  (idx_d),
        .flip (flip_d)
    );

    // Outcome state register and the registered payload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= CLEAN;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_syn   <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= rd_valid;
            if (rd_valid) begin
                kind_q   <= kind_d;
                out_data <= (kind_d == FIX_DATA) ? (rd_data ^ flip_d) : rd_data;
                out_syn  <= syn_d;
                out_idx  <= idx_d;
            end
        end
    end

    // Flags decoded from the outcome state.
    always_comb begin
        unique case (kind_q)
            CLEAN:     begin out_ce = 1'b0; out_ue = 1'b0; end
            FIX_DATA:  begin out_ce = 1'b1; out_ue = 1'b0; end
            FIX_CHECK: begin out_ce = 1'b1; out_ue = 1'b0; end
            MULTI:     begin out_ce = 1'b0; out_ue = 1'b1; end
            default:   begin out_ce = 1'b0; out_ue = 1'b0; end
        endcase
    end

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ce && out_ue));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!out_valid && $stable(out_data) && $stable(out_syn)
                       && $stable(out_idx) && $stable(out_ue)));

    // R3
    clean_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_syn == '0) |-> (!out_ce && !out_ue && out_idx == '0));

    // R6
    even_syn_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_syn != '0 && !(^out_syn)) |-> out_ue);

    // R5
    check_flip_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_syn) == 1) |-> (out_ce && out_idx >= IDX_W'(DATA_W)));

endmodule

// File: tb/secded_codec_bench.sv
`timescale 1ns/1ps
module secded_codec_bench;

    localparam int DW = 64;
    localparam int CW = 8;
    localparam int IW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wr_chk;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic [CW-1:0] rd_chk = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_syn;
    logic          out_ce;
    logic          out_ue;
    logic [IW-1:0] out_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    secded_codec u_secded_codec (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_chk(wr_chk),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
        .out_valid(out_valid), .out_data(out_data), .out_syn(out_syn),
        .out_ce(out_ce), .out_ue(out_ue), .out_idx(out_idx)
    );

    // Matrix columns from the requirement, held independently in the bench.
    localparam logic [7:0] BCOL [64] = '{
        8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
        8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
        8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
        8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
        8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
        8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
        8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
        8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B
    };

    typedef struct packed {
        logic [63:0] d;
        logic [63:0] dflip;
        logic [7:0]  cflip;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 64'h0, 8'h00},                                   // R3 clean
        '{64'hDEADBEEF01234567, 64'h20, 8'h00},                   // R4 bit 5
        '{64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 8'h00},     // R4 bit 63
        '{64'hA5A5A5A5A5A5A5A5, 64'h0, 8'h80},                    // R5 check 7
        '{64'h1234, 64'h3, 8'h00},                                // R6 two data
        '{64'hFFFF0000FFFF0000, 64'h0, 8'h03},                    // R7 syndrome 03
        '{64'h5555555555555555, 64'h400, 8'h01}                   // R6 data+check
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_decode(input logic [63:0] d, input logic [63:0] df, input logic [7:0] cf);
        logic [7:0] stored;
        logic [7:0] esyn;
        int         nflip;
        logic [IW-1:0] eidx;
        logic       ece, eue;
        @(negedge clk);
        wr_data = d;
        #1;
        stored = wr_chk;
        esyn  = cf;
        nflip = $countones(df) + $countones(cf);
        eidx  = '0;
        for (int i = 0; i < DW; i++) if (df[i]) begin esyn ^= BCOL[i]; eidx = IW'(i); end
        for (int j = 0; j < CW; j++) if (cf[j]) eidx = IW'(DW + j);
        ece = (nflip == 1);
        eue = (nflip >= 2);
        if (!ece) eidx = '0;
        rd_data  = d ^ df;
        rd_chk   = stored ^ cf;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check("R2 out_valid", 64'(out_valid), 64'd1);
        check("R2 out_syn", 64'(out_syn), 64'(esyn));
        check("R4/R5/R6 out_data", out_data, eue ? (d ^ df) : d);
        check("R4/R5 out_ce", 64'(out_ce), 64'(ece));
        check("R6 out_ue", 64'(out_ue), 64'(eue));
        check("R4/R5 out_idx", 64'(out_idx), 64'(eidx));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] all_ones;
        logic [63:0] hold_d;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_valid", 64'(out_valid), 64'd0);
        check("R9 out_data", out_data, 64'd0);
        check("R9 out_syn", 64'(out_syn), 64'd0);
        check("R9 flags", 64'({out_ce, out_ue}), 64'd0);
        check("R9 out_idx", 64'(out_idx), 64'd0);
        rst_n = 1'b1;

        // R1 encoder
        wr_data = '0; #1;
        check("R1 zero word", 64'(wr_chk), 64'd0);
        all_ones = '0;
        for (int i = 0; i < DW; i++) begin
            wr_data = 64'd1 << i; #1;
            check("R1 single bit", 64'(wr_chk), 64'(BCOL[i]));
            all_ones ^= BCOL[i];
        end
        wr_data = '1; #1;
        check("R1 all ones", 64'(wr_chk), 64'(all_ones));

        // Vector table
        for (int v = 0; v < NV; v++) run_decode(VECS[v].d, VECS[v].dflip, VECS[v].cflip);

        // R4 every data bit, R5 every check bit
        for (int i = 0; i < DW; i++) run_decode(64'h0F1E2D3C4B5A6978 ^ (64'(i) << 7), 64'd1 << i, 8'h00);
        for (int j = 0; j < CW; j++) run_decode(64'hC3C3_0000_FFFF_1234, 64'h0, 8'd1 << j);

        // R6 sampled double flips, R7 adjacent check pair
        for (int i = 0; i < DW; i++) begin
            run_decode(64'h0123456789ABCDEF, (64'd1 << i) | (64'd1 << ((i * 7 + 3) % DW)), 8'h00);
            run_decode(64'hFEDCBA9876543210, 64'd1 << i, 8'd1 << (i % CW));
        end
        run_decode(64'h0, 64'h0, 8'h03);
        check("R7 syndrome value", 64'(out_syn), 64'h03);

        // R8 hold while idle
        hold_d = out_data;
        @(negedge clk);
        rd_data = ~rd_data;
        rd_chk  = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        check("R8 out_valid low", 64'(out_valid), 64'd0);
        check("R8 data held", out_data, hold_d);
        check("R8 syn held", 64'(out_syn), 64'h03);
        check("R8 ue held", 64'(out_ue), 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule